// File: doc/BRIEF.md
# Per-Core Prescaled Tick Timer

This block is the private countdown timer of a single processor core. It has two stages. A prescaler divides the block clock by a programmable value plus one and emits one-cycle tick pulses. A second counter is loaded with a 31-bit value, counts those ticks down, and raises its pending status each time it passes zero. After that it reloads and keeps running. The block therefore delivers a steady stream of interrupts until software clears the start bits, and this holds even when the timer was armed for one event only.

Software reaches the block through a simple write port and a combinational read port inside a 256-byte window. The window holds a prescale buffer, a reload buffer guarded by an update flag, a control register, a pending-status register, an interrupt-enable register and a write-acknowledge register. Each acknowledge bit reports that a write to one of the configuration registers has taken effect. The interrupt line is the pending bit gated by the enable bit.

Top module: `core_tick_timer`

## Requirements
- R1: After a synchronous active-low reset every register in the window reads 0 and `irq_o` is low.
- R2: While the prescaler runs (control bit 0 = 1) it emits one tick every P+1 clock cycles, where P is the prescale buffer at offset 0x00.
- R3: A control write at offset 0x20 that sets bits 0 and 1 from a stopped state starts both stages. The pending bit (offset 0x30, bit 0) becomes 1 on exactly the (P+1)*(N+1)-th clock edge after that write, where N is the reload value.
- R4: After it expires, the countdown reloads N and fires again with the same period. This happens whether control bit 2 (interval mode) is 0 or 1.
- R5: A write to offset 0x08 updates the reload buffer and the active countdown only when data bit 31 is 1. In that case bits 30:0 are loaded. A write with bit 31 at 0 changes nothing.
- R6: Writing 1 to bit 0 of offset 0x30 clears the pending bit, and writing 0 has no effect. If a clear and an expiry fall on the same edge, the pending bit stays set.
- R7: `irq_o` is high exactly when the pending bit and the enable bit (offset 0x34, bit 0) are both 1.
- R8: Clearing control bits 0 and 1 freezes both stages with no further expiry. A later start reloads both counters from their buffers instead of resuming.
- R9: Offset 0x40 sets bit 0, bit 1 or bit 3 one edge after a write takes effect to 0x00, 0x08 (with update flag) or 0x20 respectively. Each bit is cleared by writing 1 to it.
- R10: Offset 0x20 reads back control bits 2:0, and any offset outside the six registers reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 8 | Byte offset of the write within the window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read within the window |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| irq_o | output | 1 | Interrupt request, pending AND enable |

## Verification
The bench goes after the exact expiry edge for several prescale and reload pairs, including the zero-prescale, zero-reload case that fires every cycle. A design that is one register slow or one count short would miss that edge by a cycle. It checks that the countdown fires a second time with interval mode off, which a design that treated the mode bit as one-shot would not do. It stops the timer partway through a period and then restarts it, so a design that resumed the old count would fire early. It also writes a clear to the pending bit on an edge where an expiry occurs, and writes the reload register without its update flag: a design that let the clear win would drop an event, and one that ignored the flag would corrupt the reload value.

// File: rtl/ctt_pkg.sv
// Shared constants for the per-core tick timer: register offsets inside
// the 256-byte window, control and acknowledge bit positions, and the
// control register layout. Assumes an 8-bit byte offset and a 32-bit bus.
package ctt_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // register offsets (software-visible, fixed)
    localparam logic [ADDR_W-1:0] OFS_PRESCALE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_PEND     = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_IEN      = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_WACK     = 8'h40;

    // update flag position in a reload write
    localparam int UPD_BIT = DATA_W - 1;

    // acknowledge bit positions
    localparam int WACK_W     = 4;
    localparam int WACK_PRESC = 0;
    localparam int WACK_RELD  = 1;
    localparam int WACK_CTRL  = 3;

    typedef struct packed {
        logic ival;      // bit 2: interval mode
        logic run_int;   // bit 1: countdown stage running
        logic run_tick;  // bit 0: prescaler running
    } ctrl_t;
endpackage

// File: rtl/ctt_regs.sv
// Register file of the tick timer. Decodes writes, holds the buffers,
// control, pending, enable and write-acknowledge state, and produces the
// start and load strobes for the counting stages. Assumes at most one
// write per cycle; reads are combinational.
module ctt_regs
    import ctt_pkg::*;
#(
    parameter int TICK_W = 32,
    parameter int CNT_W  = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                expire,
    output logic [DATA_W-1:0]   rd_data,
    output ctrl_t               ctrl_q,
    output logic [TICK_W-1:0]   tick_buf,
    output logic [CNT_W-1:0]    icnt_buf,
    output logic                icnt_load,
    output logic [CNT_W-1:0]    icnt_load_val,
    output logic                start_tick,
    output logic                start_int,
    output logic                pend_q,
    output logic                ien_q,
    output logic [WACK_W-1:0]   wack_q
);
    logic wr_presc, wr_reld, wr_ctrl, wr_pend, wr_ien, wr_wack;
    logic [WACK_W-1:0] wack_set;
    logic [WACK_W-1:0] wack_clr;

    // address decode of the write port
    always_comb begin
        wr_presc = wr_en && (wr_addr == OFS_PRESCALE);
        wr_reld  = wr_en && (wr_addr == OFS_RELOAD);
        wr_ctrl  = wr_en && (wr_addr == OFS_CTRL);
        wr_pend  = wr_en && (wr_addr == OFS_PEND);
        wr_ien   = wr_en && (wr_addr == OFS_IEN);
        wr_wack  = wr_en && (wr_addr == OFS_WACK);
    end

    // strobes towards the counting stages
    always_comb begin
        icnt_load     = wr_reld && wr_data[UPD_BIT];
        icnt_load_val = wr_data[CNT_W-1:0];
        start_tick    = wr_ctrl && wr_data[0] && !ctrl_q.run_tick;
        start_int     = wr_ctrl && wr_data[1] && !ctrl_q.run_int;
    end

    // acknowledge set and clear vectors
    always_comb begin
        wack_set = '0;
        wack_set[WACK_PRESC] = wr_presc;
        wack_set[WACK_RELD]  = icnt_load;
        wack_set[WACK_CTRL]  = wr_ctrl;
        wack_clr = wr_wack ? wr_data[WACK_W-1:0] : '0;
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_buf <= '0;
            icnt_buf <= '0;
            ctrl_q   <= '0;
            ien_q    <= 1'b0;
        end else begin
            if (wr_presc)  tick_buf <= wr_data[TICK_W-1:0];
            if (icnt_load) icnt_buf <= icnt_load_val;
            if (wr_ctrl)   ctrl_q   <= ctrl_t'(wr_data[2:0]);
            if (wr_ien)    ien_q    <= wr_data[0];
        end
    end

    // pending bit: expiry sets, write-one clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= expire || (pend_q && !(wr_pend && wr_data[0]));
    end

    // write-acknowledge bits: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) wack_q <= '0;
        else        wack_q <= wack_set | (wack_q & ~wack_clr);
    end

    // combinational read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_PRESCALE: rd_data = DATA_W'(tick_buf);
            OFS_RELOAD:   rd_data = DATA_W'(icnt_buf);
            OFS_CTRL:     rd_data = DATA_W'(ctrl_q);
            OFS_PEND:     rd_data = DATA_W'(pend_q);
            OFS_IEN:      rd_data = DATA_W'(ien_q);
            OFS_WACK:     rd_data = DATA_W'(wack_q);
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ctt_prescaler.sv
// First stage: a down-counter that emits a one-cycle tick whenever it
// passes zero while running, then reloads. Period is reload+1 cycles.
// Assumes start is only raised while run is low.
module ctt_prescaler #(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic [TICK_W-1:0] reload,
    output logic              tick,
    output logic [TICK_W-1:0] cnt
);
    // tick when the running counter sits at zero
    always_comb tick = run && (cnt == '0);

    // count down, reload at zero or on start, hold when stopped
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (start)     cnt <= reload;
        else if (tick)      cnt <= reload;
        else if (run)       cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/ctt_countdown.sv
// Second stage: counts prescaler ticks down from the reload value and
// flags expiry on the tick that finds it at zero, then reloads and keeps
// going. A buffer load with the update flag overrides the count at once.
module ctt_countdown #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);
    // expiry on a tick that finds the counter at zero
    always_comb expire = run && tick && (cnt == '0);

    // load, start, reload or decrement; hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (start)          cnt <= reload;
        else if (expire)         cnt <= reload;
        else if (run && tick)    cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/core_tick_timer.sv
// Top of the per-core tick timer: register file, prescaler and
// countdown stage. The interrupt is pending gated by enable.
// Assumes a single clock domain shared by bus and counters.
module core_tick_timer
    import ctt_pkg::*;
#(
    parameter int TICK_W = 32,
    parameter int CNT_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    ctrl_t             ctrl_q;
    logic [TICK_W-1:0] tick_buf;
    logic [TICK_W-1:0] tick_cnt;
    logic [CNT_W-1:0]  icnt_buf;
    logic [CNT_W-1:0]  icnt_load_val;
    logic [CNT_W-1:0]  int_cnt;
    logic              icnt_load, start_tick, start_int;
    logic              tick_pulse, expire, pend_q, ien_q;
    logic [WACK_W-1:0] wack_q;

    ctt_regs #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .expire(expire),
        .rd_data(rd_data), .ctrl_q(ctrl_q), .tick_buf(tick_buf),
        .icnt_buf(icnt_buf), .icnt_load(icnt_load),
        .icnt_load_val(icnt_load_val), .start_tick(start_tick),
        .start_int(start_int), .pend_q(pend_q), .ien_q(ien_q),
        .wack_q(wack_q)
    );

    ctt_prescaler #(.TICK_W(TICK_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run_tick),
        .start(start_tick), .reload(tick_buf), .tick(tick_pulse),
        .cnt(tick_cnt)
    );

    ctt_countdown #(.CNT_W(CNT_W)) u_cdown (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run_int),
        .start(start_int), .load(icnt_load), .load_val(icnt_load_val),
        .reload(icnt_buf), .tick(tick_pulse), .expire(expire),
        .cnt(int_cnt)
    );

    // interrupt request
    always_comb irq_o = pend_q && ien_q;
endmodule

// File: rtl/ctt_checker.sv
// Property checker for the tick timer, attached to every instance of the
// top module by the bind at the end of this file.
module ctt_checker #(
    parameter int TICK_W = 32,
    parameter int CNT_W  = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic              wr_flag,
    input logic              run_tick,
    input logic              run_int,
    input logic              tick_pulse,
    input logic [TICK_W-1:0] tick_cnt,
    input logic [TICK_W-1:0] tick_buf,
    input logic [CNT_W-1:0]  int_cnt,
    input logic [CNT_W-1:0]  icnt_buf,
    input logic              pend,
    input logic              ien,
    input logic              wack_ctrl,
    input logic              irq_o
);
    assert_tick_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_pulse && !(wr_en && wr_addr == 8'h00)) |=> (tick_cnt == tick_buf));

    assert_pend_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(tick_pulse && run_int && int_cnt == '0));

    assert_reload_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h08 && !wr_flag) |=> $stable(icnt_buf));

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq_o);

    assert_tick_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_tick && $past(!run_tick)) |-> $stable(tick_cnt));

    assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_int && $past(!run_int) && !$past(wr_en && wr_addr == 8'h08 && wr_flag))
        |-> $stable(int_cnt));

    assert_ctrl_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h20) |=> wack_ctrl);
endmodule

bind core_tick_timer ctt_checker #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_flag(wr_data[31]), .run_tick(ctrl_q.run_tick),
    .run_int(ctrl_q.run_int), .tick_pulse(tick_pulse),
    .tick_cnt(tick_cnt), .tick_buf(tick_buf), .int_cnt(int_cnt),
    .icnt_buf(icnt_buf), .pend(pend_q), .ien(ien_q),
    .wack_ctrl(wack_q[3]), .irq_o(irq_o)
);

// File: tb/core_tick_timer_test.sv
`timescale 1ns/10ps
module core_tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    core_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    // stimulus table: prescale P, reload N, expected period (P+1)*(N+1)
    localparam int NV = 6;
    localparam int VEC_P [NV] = '{0, 1, 3, 5, 0, 4};
    localparam int VEC_N [NV] = '{0, 2, 1, 0, 15, 3};
    localparam int VEC_T [NV] = '{1, 6, 8, 6, 16, 20};

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.1;
        d = rd_data;
    endtask

    task automatic halt_and_clear();
        wr(8'h20, 32'h0);
        wr(8'h30, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] ctl;
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h00, d); chk(d, 0, "R1 prescale after reset");
        rd(8'h08, d); chk(d, 0, "R1 reload after reset");
        rd(8'h20, d); chk(d, 0, "R1 control after reset");
        @(negedge clk);
        rd(8'h30, d); chk(d, 0, "R1 pending after reset");
        rd(8'h34, d); chk(d, 0, "R1 enable after reset");
        rd(8'h40, d); chk(d, 0, "R1 ack after reset");
        chk(irq_o, 0, "R1 irq after reset");

        // R9: write acknowledge bits
        wr(8'h00, 32'd5);
        rd(8'h40, d); chk(d, 32'h1, "R9 prescale ack");
        wr(8'h08, 32'h8000_0010);
        rd(8'h40, d); chk(d, 32'h3, "R9 reload ack");
        wr(8'h20, 32'h0);
        rd(8'h40, d); chk(d, 32'hB, "R9 control ack");
        wr(8'h40, 32'h2);
        rd(8'h40, d); chk(d, 32'h9, "R9 clear one ack bit");
        wr(8'h40, 32'hF);
        rd(8'h40, d); chk(d, 32'h0, "R9 clear all ack bits");

        // R5: update flag on the reload buffer
        wr(8'h08, 32'h0000_0033);
        rd(8'h08, d); chk(d, 32'h10, "R5 write without flag ignored");
        rd(8'h40, d); chk(d, 32'h0, "R5 no ack without flag");
        wr(8'h08, 32'h8000_0033);
        rd(8'h08, d); chk(d, 32'h33, "R5 write with flag loads");

        // R10: unused offset
        rd(8'h10, d); chk(d, 0, "R10 unused offset reads zero");

        // R2 R3 R4: table of prescale and reload values
        for (int v = 0; v < NV; v++) begin
            t = VEC_T[v];
            wr(8'h00, VEC_P[v]);
            wr(8'h08, 32'h8000_0000 | VEC_N[v]);
            wr(8'h34, 32'h1);
            ctl = (v % 2 == 1) ? 32'h7 : 32'h3;
            wr(8'h20, ctl);
            rd(8'h20, d); chk(d, ctl, "R10 control readback");
            repeat (t - 1) @(negedge clk);
            chk(irq_o, 0, "R2 R3 no early expiry");
            @(negedge clk);
            chk(irq_o, 1, "R2 R3 expiry edge");
            if (t >= 4) begin
                wr(8'h30, 32'h1);
                chk(irq_o, 0, "R6 pending cleared");
                repeat (t - 2) @(negedge clk);
                chk(irq_o, 0, "R4 no early second expiry");
                @(negedge clk);
                chk(irq_o, 1, "R4 second expiry in either mode");
            end
            halt_and_clear();
            chk(irq_o, 0, "R8 stopped and cleared");
        end

        // R7: enable gating
        wr(8'h34, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h8000_0003);
        wr(8'h20, 32'h3);
        repeat (4) @(negedge clk);
        chk(irq_o, 0, "R7 irq masked");
        rd(8'h30, d); chk(d, 1, "R7 pending set while masked");
        wr(8'h34, 32'h1);
        chk(irq_o, 1, "R7 irq after enable");
        wr(8'h20, 32'h0);

        // R6: writing zero leaves pending, one clears
        wr(8'h30, 32'h0);
        rd(8'h30, d); chk(d, 1, "R6 write zero no effect");
        wr(8'h30, 32'h1);
        rd(8'h30, d); chk(d, 0, "R6 write one clears");

        // R6: set wins over clear on the same edge
        wr(8'h08, 32'h8000_0000);
        wr(8'h20, 32'h3);
        repeat (2) @(negedge clk);
        wr(8'h30, 32'h1);
        rd(8'h30, d); chk(d, 1, "R6 expiry wins over clear");
        halt_and_clear();

        // R8: freeze mid-period, then restart reloads
        wr(8'h00, 32'h1);
        wr(8'h08, 32'h8000_0004);
        wr(8'h20, 32'h3);
        repeat (5) @(negedge clk);
        wr(8'h20, 32'h0);
        repeat (20) @(negedge clk);
        chk(irq_o, 0, "R8 no expiry while frozen");
        rd(8'h30, d); chk(d, 0, "R8 pending clear while frozen");
        wr(8'h20, 32'h3);
        repeat (9) @(negedge clk);
        chk(irq_o, 0, "R8 restart does not resume old count");
        @(negedge clk);
        chk(irq_o, 1, "R8 restart full period");
        halt_and_clear();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule